// File: doc/BRIEF.md
# Multi-Channel Transcoder Initialization Sequencer

This block brings the shared state memory of a four-channel transcoder to its default contents and then hands out the channels in turn. A power-on pulse, or an active-low warm reset held for long enough, starts a full clear. The clear walks every state-memory address through a single write port, one address per clock. The whole phase takes a fixed number of master clock cycles. Until the first falling edge of the frame-enable strobe after the clear, the block reports busy and forces the serial data path to zero.

In normal running, each accepted falling edge of the frame enable serves one channel from a round-robin pointer. If the init request input is high at that edge, the request and the four configuration bits are captured: a law-select bit, an enable bit and a two-bit rate code. Only the served channel is then re-initialized over a longer frame, which writes that channel's slice of the state memory. The contents of the default word and the channel datapath live outside this block.

Top module: `xcodeInitSeq`

## Requirements
- R1: A low pulse on `rstNIn` that is seen at only one rising clock edge is ignored: `busy`, `clrDone` and the channel pointer keep their values.
- R2: `rstNIn` seen low at two consecutive rising edges is accepted at the second edge. From that edge on, `busy` is 1, `clrDone` is 0, `chanInit` is 0, and the channel pointer returns to channel 0.
- R3: The full clear starts at the first rising edge that sees the reset released and lasts exactly 726 cycles. `clrDone` rises on the 727th edge.
- R4: During the clear, `memWrEn` is high on the first 128 clear cycles. `memWrAddr` runs 0,1,…,127 in ascending order and `memWrData` equals the default word. There are no further writes for the rest of the clear.
- R5: An accepted reset during a clear aborts it. After the new release, the full 726-cycle count starts again from zero.
- R6: `busy` stays 1 through the clear and afterwards until the first falling edge of `frameEn` that arrives after `clrDone` is high. Falling edges during the clear serve no channel.
- R7: `serDataOut` is 0 while `busy` is 1 and equals `serDataIn` otherwise.
- R8: Each served falling edge presents the pointer's channel on `chanSel` in the following cycle. The pointer then advances 0→1→2→3→0. The first frame after any full clear serves channel 0.
- R9: When `initReq` is high at a served falling edge, `lawQ`, `enableQ` and `rateQ` take `cfgLaw`, `cfgEnable` and `cfgRate` from that edge. They hold those values until the next init edge.
- R10: A channel init keeps `chanInit` high for exactly 45 cycles. During its first 32 cycles it writes the default word to address `chan*32 + k` for k = 0…31, with the channel in the upper two address bits. It writes nothing in the remaining cycles.
- R11: Falling edges of `frameEn` while `chanInit` is high are ignored. They do not advance the pointer, change `chanSel`, or capture configuration.
- R12: `porIn` high asynchronously puts the block in the reset state: `busy` 1, `clrDone` 0, `chanSel` 0, `chanInit` 0, no writes. Its release starts the same 726-cycle clear as a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| porIn | input | 1 | Power-on reset, active high, asynchronous |
| rstNIn | input | 1 | Warm reset, active low, sampled by `clk` |
| frameEn | input | 1 | Frame enable strobe; its falling edge serves a channel |
| initReq | input | 1 | Single-channel init request, sampled at the falling edge of `frameEn` |
| cfgLaw | input | 1 | Law-select configuration bit |
| cfgEnable | input | 1 | Channel enable configuration bit |
| cfgRate | input | 2 | Rate-select configuration code |
| serDataIn | input | 1 | Serial data from the line side |
| busy | output | 1 | Full initialization in progress or awaiting first frame |
| clrDone | output | 1 | Memory clear finished |
| chanSel | output | 2 | Channel served by the current frame |
| chanInit | output | 1 | Single-channel init frame in progress |
| lawQ | output | 1 | Captured law-select bit |
| enableQ | output | 1 | Captured enable bit |
| rateQ | output | 2 | Captured rate code |
| memWrEn | output | 1 | State memory write enable |
| memWrAddr | output | 7 | State memory write address |
| memWrData | output | 16 | State memory write data (default word) |
| serDataOut | output | 1 | Serial data, gated to 0 while busy |

## Verification
A clear counter that starts from the wrong value or stops at the wrong value shows up as `clrDone` rising early or late. It also shows up as a write-address sequence that skips an address or stops short of 127. Both appear within the one clear. A pointer that advances on an ignored edge or misses a wrap shows a wrong `chanSel` on the very next served frame. A lost or extended init count changes the number of `chanInit` cycles and the addresses written in that frame. A reset filter with the wrong length makes `busy` rise one edge early, one edge late, or not at all.

// File: rtl/xinit_pkg.sv
`timescale 1ns/1ps
package xinit_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } seqState_t;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clrStart;
    logic clrStep;
    logic frameTake;
    logic initStart;
    logic ptrReset;
    logic initAbort;
  } seqStrobe_t;

  // Status returned by the datapath
  typedef struct packed {
    logic clrLast;
    logic initBusy;
  } seqStatus_t;

endpackage

// File: rtl/xinit_ctrl.sv
`timescale 1ns/1ps
module xinit_ctrl
  import xinit_pkg::*;
#(
  parameter int RST_MIN_LOW = 2
) (
  input  logic       clk,
  input  logic       porIn,
  input  logic       rstNIn,
  input  logic       frameEn,
  input  logic       initReq,
  input  seqStatus_t stat,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       clrDone
);

  localparam int LOW_W = (RST_MIN_LOW > 1) ? $clog2(RST_MIN_LOW) : 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(RST_MIN_LOW - 1);

  logic [LOW_W-1:0] lowCnt;
  logic             ceQ;
  seqState_t        state, stateNxt;
  logic             accept;
  logic             fall;

  assign accept = !rstNIn && (lowCnt == LOW_LAST);
  assign fall   = ceQ && !frameEn;

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      lowCnt <= '0;
      ceQ    <= 1'b0;
      state  <= ST_HOLD;
    end else begin
      if (rstNIn)                  lowCnt <= '0;
      else if (lowCnt != LOW_LAST) lowCnt <= lowCnt + 1'b1;
      ceQ   <= frameEn;
      state <= stateNxt;
    end
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    if (accept) begin
      stb.ptrReset  = 1'b1;
      stb.initAbort = 1'b1;
      stateNxt      = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (rstNIn) begin
            stb.clrStart = 1'b1;
            stateNxt     = ST_CLEAR;
          end
        end
        ST_CLEAR: begin
          stb.clrStep = 1'b1;
          if (stat.clrLast) stateNxt = ST_WAIT;
        end
        ST_WAIT: begin
          if (fall) begin
            stb.frameTake = 1'b1;
            stb.initStart = initReq;
            stateNxt      = ST_RUN;
          end
        end
        ST_RUN: begin
          if (fall && !stat.initBusy) begin
            stb.frameTake = 1'b1;
            stb.initStart = initReq;
          end
        end
        default: stateNxt = ST_HOLD;
      endcase
    end
  end

  assign busy    = (state != ST_RUN);
  assign clrDone = (state == ST_WAIT) || (state == ST_RUN);

  // R2
  rst_accept_chk: assert property (@(posedge clk) disable iff (porIn)
    (!rstNIn && $past(!rstNIn)) |=> (busy && !clrDone));

  // R3
  clear_end_chk: assert property (@(posedge clk) disable iff (porIn)
    $rose(clrDone) |-> $past(stat.clrLast));

  // R6
  resume_chk: assert property (@(posedge clk) disable iff (porIn)
    $fell(busy) |-> ($past(clrDone) && $past(ceQ) && !$past(frameEn)));

endmodule

// File: rtl/xinit_dpath.sv
`timescale 1ns/1ps
module xinit_dpath
  import xinit_pkg::*;
#(
  parameter int              CHANNELS     = 4,
  parameter int              ENTRIES      = 32,
  parameter int              WORD_W       = 16,
  parameter logic [WORD_W-1:0] DFLT_WORD  = 16'h0000,
  parameter int              CLEAR_CYCLES = 726,
  parameter int              INIT_CYCLES  = 45,
  localparam int             CH_W         = $clog2(CHANNELS),
  localparam int             ENT_W        = $clog2(ENTRIES),
  localparam int             ADDR_W       = CH_W + ENT_W
) (
  input  logic              clk,
  input  logic              porIn,
  input  seqStrobe_t        stb,
  input  logic              busy,
  input  logic              cfgLaw,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgRate,
  input  logic              serDataIn,
  output seqStatus_t        stat,
  output logic [CH_W-1:0]   chanSel,
  output logic              chanInit,
  output logic              lawQ,
  output logic              enableQ,
  output logic [1:0]        rateQ,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              serDataOut
);

  localparam int DEPTH = CHANNELS * ENTRIES;
  localparam int CLR_W = $clog2(CLEAR_CYCLES);
  localparam int INI_W = $clog2(INIT_CYCLES);
  localparam logic [CLR_W-1:0] CLR_LAST  = CLR_W'(CLEAR_CYCLES - 1);
  localparam logic [CLR_W-1:0] CLR_DEPTH = CLR_W'(DEPTH);
  localparam logic [INI_W-1:0] INI_LAST  = INI_W'(INIT_CYCLES - 1);
  localparam logic [INI_W-1:0] INI_ENT   = INI_W'(ENTRIES);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(CHANNELS - 1);

  logic [CLR_W-1:0] clrCnt;
  logic [INI_W-1:0] initCnt;
  logic [CH_W-1:0]  chPtr;
  logic             clrWr, initWr;

  // Clear address walker
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)             clrCnt <= '0;
    else if (stb.clrStart) clrCnt <= '0;
    else if (stb.clrStep)  clrCnt <= clrCnt + 1'b1;
  end

  // Round-robin channel pointer and served channel
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      chPtr   <= '0;
      chanSel <= '0;
    end else if (stb.ptrReset) begin
      chPtr   <= '0;
      chanSel <= '0;
    end else if (stb.frameTake) begin
      chanSel <= chPtr;
      chPtr   <= (chPtr == CH_LAST) ? '0 : chPtr + 1'b1;
    end
  end

  // Single-channel init frame counter
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      chanInit <= 1'b0;
      initCnt  <= '0;
    end else if (stb.initAbort) begin
      chanInit <= 1'b0;
      initCnt  <= '0;
    end else if (stb.initStart) begin
      chanInit <= 1'b1;
      initCnt  <= '0;
    end else if (chanInit) begin
      if (initCnt == INI_LAST) begin
        chanInit <= 1'b0;
        initCnt  <= '0;
      end else begin
        initCnt  <= initCnt + 1'b1;
      end
    end
  end

  // Captured configuration
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      lawQ    <= 1'b0;
      enableQ <= 1'b0;
      rateQ   <= 2'b00;
    end else if (stb.initStart) begin
      lawQ    <= cfgLaw;
      enableQ <= cfgEnable;
      rateQ   <= cfgRate;
    end
  end

  assign clrWr     = stb.clrStep && (clrCnt < CLR_DEPTH);
  assign initWr    = chanInit && (initCnt < INI_ENT);
  assign memWrEn   = clrWr || initWr;
  assign memWrAddr = initWr ? {chanSel, initCnt[ENT_W-1:0]} : clrCnt[ADDR_W-1:0];
  assign memWrData = memWrEn ? DFLT_WORD : '0;

  assign serDataOut    = serDataIn && !busy;
  assign stat.clrLast  = (clrCnt == CLR_LAST);
  assign stat.initBusy = chanInit;

  // R10
  init_len_chk: assert property (@(posedge clk) disable iff (porIn)
    ($fell(chanInit) && !$past(stb.initAbort)) |-> ($past(initCnt) == INI_LAST));

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (porIn)
    (stb.frameTake && !stb.ptrReset && chPtr == CH_LAST) |=> (chPtr == '0));

  // R11
  init_hold_chk: assert property (@(posedge clk) disable iff (porIn)
    (chanInit && $past(chanInit)) |-> $stable(chanSel));

endmodule

// File: rtl/xcodeInitSeq.sv
`timescale 1ns/1ps
module xcodeInitSeq
  import xinit_pkg::*;
#(
  parameter int                CHANNELS     = 4,
  parameter int                ENTRIES      = 32,
  parameter int                WORD_W       = 16,
  parameter logic [WORD_W-1:0] DFLT_WORD    = 16'h5A3C,
  parameter int                CLEAR_CYCLES = 726,
  parameter int                INIT_CYCLES  = 45,
  parameter int                RST_MIN_LOW  = 2,
  localparam int               CH_W         = $clog2(CHANNELS),
  localparam int               ADDR_W       = CH_W + $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              rstNIn,
  input  logic              frameEn,
  input  logic              initReq,
  input  logic              cfgLaw,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgRate,
  input  logic              serDataIn,
  output logic              busy,
  output logic              clrDone,
  output logic [CH_W-1:0]   chanSel,
  output logic              chanInit,
  output logic              lawQ,
  output logic              enableQ,
  output logic [1:0]        rateQ,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData,
  output logic              serDataOut
);

  seqStrobe_t stb;
  seqStatus_t stat;

  xinit_ctrl #(.RST_MIN_LOW(RST_MIN_LOW)) uCtrl (
    .clk     (clk),
    .porIn   (porIn),
    .rstNIn  (rstNIn),
    .frameEn (frameEn),
    .initReq (initReq),
    .stat    (stat),
    .stb     (stb),
    .busy    (busy),
    .clrDone (clrDone)
  );

  xinit_dpath #(
    .CHANNELS     (CHANNELS),
    .ENTRIES      (ENTRIES),
    .WORD_W       (WORD_W),
    .DFLT_WORD    (DFLT_WORD),
    .CLEAR_CYCLES (CLEAR_CYCLES),
    .INIT_CYCLES  (INIT_CYCLES)
  ) uDpath (
    .clk        (clk),
    .porIn      (porIn),
    .stb        (stb),
    .busy       (busy),
    .cfgLaw     (cfgLaw),
    .cfgEnable  (cfgEnable),
    .cfgRate    (cfgRate),
    .serDataIn  (serDataIn),
    .stat       (stat),
    .chanSel    (chanSel),
    .chanInit   (chanInit),
    .lawQ       (lawQ),
    .enableQ    (enableQ),
    .rateQ      (rateQ),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData),
    .serDataOut (serDataOut)
  );

  // R4
  wr_source_chk: assert property (@(posedge clk) disable iff (porIn)
    memWrEn |-> ((busy && !clrDone) || chanInit));

  // R9
  init_run_chk: assert property (@(posedge clk) disable iff (porIn)
    $rose(chanInit) |-> !busy);

endmodule

// File: tb/tb_xcodeInitSeq.sv
`timescale 1ns/1ps
module tb_xcodeInitSeq;

  localparam int CLR   = 726;
  localparam int DEPTH = 128;
  localparam int ENT   = 32;
  localparam int INITC = 45;
  localparam logic [15:0] DFLT = 16'h5A3C;

  logic clk = 1'b0;
  logic porIn = 1'b1, rstNIn = 1'b1, frameEn = 1'b0, initReq = 1'b0;
  logic cfgLaw = 1'b0, cfgEnable = 1'b0, serDataIn = 1'b0;
  logic [1:0] cfgRate = 2'b00;
  logic busy, clrDone, chanInit, lawQ, enableQ, memWrEn, serDataOut;
  logic [1:0] chanSel, rateQ;
  logic [6:0] memWrAddr;
  logic [15:0] memWrData;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xcodeInitSeq dut (
    .clk(clk), .porIn(porIn), .rstNIn(rstNIn), .frameEn(frameEn), .initReq(initReq),
    .cfgLaw(cfgLaw), .cfgEnable(cfgEnable), .cfgRate(cfgRate), .serDataIn(serDataIn),
    .busy(busy), .clrDone(clrDone), .chanSel(chanSel), .chanInit(chanInit),
    .lawQ(lawQ), .enableQ(enableQ), .rateQ(rateQ), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .serDataOut(serDataOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called right after the reset release was driven at a falling clock edge
  task automatic doClear(input string req);
    int clrCyc = 0, wr = 0, addrErr = 0, dataErr = 0, busyErr = 0, serErr = 0, chErr = 0;
    bit seen = 1'b0;
    for (int k = 1; k <= 1000 && !seen; k++) begin
      @(negedge clk);
      frameEn   = (k >= 6 && k < 700) ? k[2] : 1'b0;
      serDataIn = 1'b1;
      #1;
      if (!clrDone) begin
        clrCyc++;
        if (memWrEn) begin
          if (int'(memWrAddr) != wr) addrErr++;
          if (memWrData != DFLT) dataErr++;
          wr++;
        end
      end else seen = 1'b1;
      if (!busy) busyErr++;
      if (serDataOut) serErr++;
      if (chanSel != 2'd0) chErr++;
    end
    frameEn = 1'b0;
    chk({req, " R3"}, "clear cycles", clrCyc, CLR);
    chk("R4", "clear writes", wr, DEPTH);
    chk("R4", "clear address order errors", addrErr, 0);
    chk("R4", "clear data errors", dataErr, 0);
    chk("R6", "busy low during clear", busyErr, 0);
    chk("R6", "channel served during clear", chErr, 0);
    chk("R7", "serial data leaked while busy", serErr, 0);
  endtask

  task automatic plainFrame(input int expCh, input string req);
    @(negedge clk); frameEn = 1'b1; initReq = 1'b0;
    @(negedge clk);
    @(negedge clk); frameEn = 1'b0;
    @(negedge clk); #1;
    chk(req, "served channel", int'(chanSel), expCh);
    chk(req, "busy after frame", int'(busy), 0);
    chk(req, "no channel init", int'(chanInit), 0);
  endtask

  task automatic initFrame(input int expCh, input logic [3:0] cfg, input bit glitch);
    int hi = 0, wrErr = 0, selErr = 0, cfgErr = 0;
    bit endSeen = 1'b0;
    @(negedge clk);
    frameEn = 1'b1; initReq = 1'b1;
    cfgLaw = cfg[3]; cfgEnable = cfg[2]; cfgRate = cfg[1:0];
    @(negedge clk);
    @(negedge clk); frameEn = 1'b0;
    for (int n = 1; n <= 60 && !endSeen; n++) begin
      @(negedge clk);
      if (n == 3) begin
        cfgLaw = ~cfg[3]; cfgEnable = ~cfg[2]; cfgRate = ~cfg[1:0];
      end
      if (glitch && n == 8)  frameEn = 1'b1;
      if (glitch && n == 10) frameEn = 1'b0;
      #1;
      if (chanInit) begin
        hi++;
        if (hi <= ENT) begin
          if (!memWrEn || int'(memWrAddr) != expCh * ENT + hi - 1 || memWrData != DFLT) wrErr++;
        end else if (memWrEn) wrErr++;
        if (int'(chanSel) != expCh) selErr++;
        if ({lawQ, enableQ, rateQ} != cfg) cfgErr++;
      end else endSeen = 1'b1;
    end
    initReq = 1'b0;
    chk("R10", "init frame length", hi, INITC);
    chk("R10", "init write errors", wrErr, 0);
    chk("R11", "channel changed during init", selErr, 0);
    chk("R9", "captured config errors", cfgErr, 0);
    chk("R9", "captured config value", int'({lawQ, enableQ, rateQ}), int'(cfg));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R12: power-on reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "busy under por", int'(busy), 1);
    chk("R12", "clrDone under por", int'(clrDone), 0);
    chk("R12", "chanSel under por", int'(chanSel), 0);
    chk("R12", "chanInit under por", int'(chanInit), 0);
    chk("R12", "memWrEn under por", int'(memWrEn), 0);
    @(negedge clk); porIn = 1'b0;
    doClear("R12");

    // R6: still busy after clear until a falling edge
    repeat (3) @(negedge clk);
    serDataIn = 1'b1; #1;
    chk("R6", "busy waiting for frame", int'(busy), 1);
    chk("R6", "clrDone after clear", int'(clrDone), 1);
    chk("R7", "serial gated while waiting", int'(serDataOut), 0);
    plainFrame(0, "R6");
    #1;
    chk("R7", "serial passes when running", int'(serDataOut), 1);
    serDataIn = 1'b0; #1;
    chk("R7", "serial passes zero", int'(serDataOut), 0);

    // R8: round robin with wrap
    for (int i = 1; i <= 8; i++) plainFrame(i % 4, "R8");

    // R9 R10 R11: sweep all configuration codes, glitch edges on odd ones
    for (int c = 0; c < 16; c++) begin
      initFrame((1 + c) % 4, 4'(c), c[0]);
    end
    plainFrame(1, "R11");

    // R1: one-edge low pulse ignored
    @(negedge clk); rstNIn = 1'b0;
    @(negedge clk); rstNIn = 1'b1; #1;
    chk("R1", "busy after short pulse", int'(busy), 0);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy later", int'(busy), 0);
    chk("R1", "clrDone kept", int'(clrDone), 1);
    plainFrame(2, "R1");

    // R2: accepted reset aborts a channel init and resets the pointer
    @(negedge clk); frameEn = 1'b1; initReq = 1'b1;
    @(negedge clk);
    @(negedge clk); frameEn = 1'b0;
    repeat (5) @(negedge clk);
    initReq = 1'b0; #1;
    chk("R2", "init running before reset", int'(chanInit), 1);
    @(negedge clk); rstNIn = 1'b0;
    @(negedge clk); #1;
    chk("R2", "busy after one low edge", int'(busy), 0);
    @(negedge clk); #1;
    chk("R2", "busy after two low edges", int'(busy), 1);
    chk("R2", "clrDone after accept", int'(clrDone), 0);
    chk("R2", "chanInit aborted", int'(chanInit), 0);
    chk("R2", "chanSel reset", int'(chanSel), 0);
    repeat (3) @(negedge clk);
    rstNIn = 1'b1;

    // R5: reset in the middle of a clear restarts the count
    repeat (300) @(negedge clk);
    #1;
    chk("R5", "clear still running", int'(clrDone), 0);
    rstNIn = 1'b0;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R5", "busy on restart", int'(busy), 1);
    rstNIn = 1'b1;
    doClear("R5");
    plainFrame(0, "R2");
    plainFrame(1, "R8");

    // R12: power-on reset in running mode
    @(negedge clk); porIn = 1'b1; #1;
    chk("R12", "busy on por", int'(busy), 1);
    chk("R12", "chanSel on por", int'(chanSel), 0);
    @(negedge clk); porIn = 1'b0;
    doClear("R12");
    plainFrame(0, "R12");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule